// File: doc/BRIEF.md
# Interrupt Pin Remap Register File

This block decides which of eight shared interrupt request lines (PIRQ A to H, indices 0 to 7) each interrupt pin of each device slot drives. Slots 25 to 31 each own a 16-bit remap register in a 64-byte little-endian configuration window. Every register holds four 4-bit fields, one per pin (INTA to INTD, pin index 0 to 3). Field n sits at bits [4n+3:4n], and only the low three bits of a field select the line. Slot 30 has no storage: it reads as zero, ignores writes and always routes pin n to line n+4. Slots 0 to 24 have no register either; they use a rotating default that keeps lines A to D free for other users.

Software reaches the window through a valid/ready request port and a valid/ready read-response port. Only the low six address bits select a byte, so any wider address aliases into the window. An access of 1 to 4 bytes is cut short at the window end instead of wrapping. A second, purely combinational port gives the routing: present a slot and a pin and read back the 3-bit line index. Each accepted write raises a one-cycle routing-changed pulse so consumers can refresh any cached routing.

Top module: `pin_route_regs`

## Requirements
- R1: On reset every live slot register (slots 25-29 and 31) holds 16'h3210. Slot 30's register bytes read zero. No read response is pending and route_chg is low.
- R2: For slots 25-29 and 31, lk_pirq equals bits [4n+2:4n] of that slot's register for pin n. Bit 4n+3 has no effect on the result.
- R3: For slot 30, lk_pirq equals pin+4 at all times. Its window bytes (offsets 10 and 11) read zero and writes to them change nothing.
- R4: For slots 0 to 24, lk_pirq equals ((slot+pin) mod 4)+4.
- R5: Slot s's register sits at byte offsets 2*(s-25) (low byte) and 2*(s-25)+1 (high byte). An access of req_len+1 bytes maps data byte k (bits [8k+7:8k]) to offset addr+k, little-endian.
- R6: Only req_addr[5:0] selects the starting byte; the higher address bits are ignored.
- R7: Any byte whose offset addr+k would be 64 or more is dropped. On a write it is not stored and does not wrap to offset 0. On a read it returns zero.
- R8: Offsets 14 to 63 are unimplemented: they read zero and writes to them change no register or route.
- R9: route_chg is high for exactly the one cycle after each accepted write and low otherwise. lk_pirq shows a written value from the cycle after acceptance; in the acceptance cycle it still shows the old value.
- R10: req_ready is high when no response is pending or rsp_ready is high. An accepted read gives rsp_valid the next cycle. While rsp_valid is high and rsp_ready low, rsp_rdata stays stable and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; only bits [5:0] are used |
| req_len | input | 2 | Access length in bytes minus one |
| req_wdata | input | 32 | Little-endian write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Little-endian read data, zero in dropped lanes |
| route_chg | output | 1 | One-cycle pulse after each accepted write |
| lk_slot | input | 5 | Slot number to look up |
| lk_pin | input | 2 | Pin index, 0 = INTA to 3 = INTD |
| lk_pirq | output | 3 | Line index, 0 = PIRQ A to 7 = PIRQ H |

## Verification
Two things can meet in one cycle: a write accepted while the lookup port is sampling the same slot, and a new request landing on the edge where a stalled read response drains. The bench holds a lookup on a slot while a write to its field is presented. It checks the old index before the edge and the new one after it, along with the routing-changed pulse. It also stalls a read response with a write queued behind it, checks that the write is refused and the data held, and then releases both on one edge. It expects the response to clear, the write to land and the pulse to follow, all on that single edge.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
  localparam int PINS    = 4;
  localparam int PIRQ_W  = 3;
  localparam int FIELD_W = 4;
  localparam int REG_W   = PINS * FIELD_W;
  localparam int LANES   = 4;
  localparam int DATA_W  = LANES * 8;

  typedef logic [PIRQ_W-1:0] pirq_t;

  // rotating default for slots without a remap register: upper four lines only
  function automatic pirq_t rotate_default(input int slot, input int pin);
    return pirq_t'(((slot + pin) % 4) + 4);
  endfunction
endpackage

// File: rtl/pin_route_bus.sv
module pin_route_bus
  import pin_route_pkg::*;
#(
  parameter int BUS_ADDR_W = 16,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [BUS_ADDR_W-1:0] req_addr,
  input  logic [1:0]            req_len,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  route_chg,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     acc_addr,
  output logic [1:0]            acc_len,
  output logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W-1:0]     rd_data
);
  logic fire;
  logic addr_hi_unused;

  // a pending response blocks new requests unless it drains this same edge
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_en     = fire && req_write;

  // window decode: only the low address bits select a byte
  assign acc_addr       = req_addr[ADDR_W-1:0];
  assign addr_hi_unused = ^req_addr[BUS_ADDR_W-1:ADDR_W];
  assign acc_len        = req_len;
  assign wr_data        = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      route_chg <= 1'b0;
    end else begin
      route_chg <= wr_en;
      if (fire && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled response keeps its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/pin_route_bank.sv
module pin_route_bank
  import pin_route_pkg::*;
#(
  parameter int                 WIN_BYTES   = 64,
  parameter int                 NUM_REGS    = 7,
  parameter int                 FIXED_IDX   = 5,
  parameter logic [REG_W-1:0]   DEFAULT_MAP = 16'h3210,
  localparam int                ADDR_W      = $clog2(WIN_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [1:0]                acc_len,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  logic [LANES-1:0]  lane_ok;
  logic [ADDR_W-1:0] lane_idx [LANES];

  // per-lane byte offset, with clipping at the window end instead of wrap
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0] off;
    logic            len_ok;
    assign off = {1'b0, acc_addr} + (ADDR_W+1)'(k);
    if (k == 0) begin : g_first
      assign len_ok = 1'b1;
    end else begin : g_more
      assign len_ok = (acc_len >= 2'(k));
    end
    assign lane_ok[k]  = len_ok && !off[ADDR_W];
    assign lane_idx[k] = off[ADDR_W-1:0];
  end

  // one register per slot; the fixed slot has no storage
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFF_LO = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] OFF_HI = ADDR_W'(2 * i + 1);
    if (i == FIXED_IDX) begin : g_fixed
      assign regs_flat[i*REG_W +: REG_W] = '0;
    end else begin : g_live
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= DEFAULT_MAP;
        end else if (wr_en) begin
          for (int k = 0; k < LANES; k++) begin
            if (lane_ok[k] && lane_idx[k] == OFF_LO) q[7:0]  <= wr_data[8*k +: 8];
            if (lane_ok[k] && lane_idx[k] == OFF_HI) q[15:8] <= wr_data[8*k +: 8];
          end
        end
      end
      assign regs_flat[i*REG_W +: REG_W] = q;
    end
  end

  // read mux: unimplemented or clipped lanes return zero
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_ok[k]) begin
        for (int b = 0; b < 2 * NUM_REGS; b++) begin
          if (lane_idx[k] == ADDR_W'(b)) rd_data[8*k +: 8] = regs_flat[8*b +: 8];
        end
      end
    end
  end

  // R8: without a write no register moves
  p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/pin_route_lookup.sv
module pin_route_lookup
  import pin_route_pkg::*;
#(
  parameter int FIRST_SLOT = 25,
  parameter int LAST_SLOT  = 31,
  parameter int FIXED_SLOT = 30,
  parameter int SLOT_W     = 5,
  localparam int NUM_REGS  = LAST_SLOT - FIRST_SLOT + 1
) (
  input  logic [NUM_REGS*REG_W-1:0] regs_flat,
  input  logic [SLOT_W-1:0]         lk_slot,
  input  logic [1:0]                lk_pin,
  output pirq_t                     lk_pirq
);
  int s;
  int p;
  int idx;

  always_comb begin
    s   = int'(lk_slot);
    p   = int'(lk_pin);
    idx = 0;
    if (s == FIXED_SLOT) begin
      lk_pirq = pirq_t'(p + 4);
    end else if (s >= FIRST_SLOT && s <= LAST_SLOT) begin
      idx     = s - FIRST_SLOT;
      lk_pirq = regs_flat[idx*REG_W + p*FIELD_W +: PIRQ_W];
    end else begin
      lk_pirq = rotate_default(s, p);
    end
  end
endmodule

// File: rtl/pin_route_regs.sv
module pin_route_regs
  import pin_route_pkg::*;
#(
  parameter int               BUS_ADDR_W  = 16,
  parameter int               WIN_BYTES   = 64,
  parameter int               FIRST_SLOT  = 25,
  parameter int               LAST_SLOT   = 31,
  parameter int               FIXED_SLOT  = 30,
  parameter int               SLOT_W      = 5,
  parameter logic [15:0]      DEFAULT_MAP = 16'h3210
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [BUS_ADDR_W-1:0] req_addr,
  input  logic [1:0]            req_len,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic                  route_chg,
  input  logic [SLOT_W-1:0]     lk_slot,
  input  logic [1:0]            lk_pin,
  output logic [2:0]            lk_pirq
);
  localparam int ADDR_W    = $clog2(WIN_BYTES);
  localparam int NUM_REGS  = LAST_SLOT - FIRST_SLOT + 1;
  localparam int FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

  logic                      wr_en;
  logic [ADDR_W-1:0]         acc_addr;
  logic [1:0]                acc_len;
  logic [DATA_W-1:0]         wr_data;
  logic [DATA_W-1:0]         rd_data;
  logic [NUM_REGS*REG_W-1:0] regs_flat;

  pin_route_bus #(.BUS_ADDR_W(BUS_ADDR_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .route_chg(route_chg), .wr_en(wr_en), .acc_addr(acc_addr),
    .acc_len(acc_len), .wr_data(wr_data), .rd_data(rd_data)
  );

  pin_route_bank #(.WIN_BYTES(WIN_BYTES), .NUM_REGS(NUM_REGS),
                   .FIXED_IDX(FIXED_IDX), .DEFAULT_MAP(DEFAULT_MAP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
    .acc_len(acc_len), .wr_data(wr_data), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );

  pin_route_lookup #(.FIRST_SLOT(FIRST_SLOT), .LAST_SLOT(LAST_SLOT),
                     .FIXED_SLOT(FIXED_SLOT), .SLOT_W(SLOT_W)) u_lookup (
    .regs_flat(regs_flat), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_pirq(lk_pirq)
  );

  // R9: accepted write is followed by the pulse, nothing else raises it
  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> route_chg);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> !route_chg);
  // R10: accepted read produces a response on the next cycle
  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  // R3: the fixed slot always lands on the upper lines, pin for pin
  p_fixed_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_slot) == FIXED_SLOT) |-> (lk_pirq[2] && lk_pirq[1:0] == lk_pin));
  // R4: slots without a register never use the lower four lines
  p_low_slots_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_slot) < FIRST_SLOT) |-> lk_pirq[2]);
endmodule

// File: tb/pin_route_regs_test.sv
module pin_route_regs_test;
  localparam int NREG  = 7;
  localparam int FIRST = 25;
  localparam int LAST  = 31;
  localparam int FIXED = 30;
  localparam int WIN   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        route_chg;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_reg [NREG];

  always #4 clk = ~clk;

  pin_route_regs uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .route_chg(route_chg), .lk_slot(lk_slot),
    .lk_pin(lk_pin), .lk_pirq(lk_pirq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model byte at a window offset (R3, R5, R8)
  function automatic logic [7:0] m_byte(input int off);
    int i;
    if (off >= 2 * NREG) return 8'h00;
    i = off / 2;
    if (i == FIXED - FIRST) return 8'h00;
    return (off % 2 == 1) ? m_reg[i][15:8] : m_reg[i][7:0];
  endfunction

  // R5, R6, R7: expected read data
  function automatic logic [31:0] exp_read(input int a, input int len);
    logic [31:0] d;
    int off;
    d = '0;
    for (int k = 0; k < 4; k++) begin
      off = (a % WIN) + k;
      if (k <= len && off < WIN) d[8*k +: 8] = m_byte(off);
    end
    return d;
  endfunction

  task automatic m_write(input int a, input int len, input logic [31:0] d);
    int off;
    for (int k = 0; k < 4; k++) begin
      off = (a % WIN) + k;
      if (k <= len && off < 2 * NREG && off / 2 != FIXED - FIRST) begin
        if (off % 2 == 1) m_reg[off/2][15:8] = d[8*k +: 8];
        else              m_reg[off/2][7:0]  = d[8*k +: 8];
      end
    end
  endtask

  // R2, R3, R4: expected route
  function automatic logic [2:0] exp_route(input int s, input int p);
    if (s == FIXED) return 3'(p + 4);
    if (s >= FIRST && s <= LAST) return m_reg[s-FIRST][4*p +: 3];
    return 3'(((s + p) % 4) + 4);
  endfunction

  function automatic string route_tag(input int s);
    if (s == FIXED) return "R3";
    if (s >= FIRST) return "R2";
    return "R4";
  endfunction

  task automatic check_route(input int s, input int p, input string tag);
    lk_slot = 5'(s);
    lk_pin  = 2'(p);
    #1;
    check(lk_pirq == exp_route(s, p), tag, 32'(lk_pirq), 32'(exp_route(s, p)));
  endtask

  task automatic sweep_routes();
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) check_route(s, p, route_tag(s));
  endtask

  task automatic bus_write(input logic [15:0] a, input int len, input logic [31:0] d,
                           input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    req_len = 2'(len); req_wdata = d;
    #1 check(req_ready == 1'b1, "R10 ready idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(route_chg == 1'b1, "R9 pulse", 32'(route_chg), 32'd1);
    m_write(int'(a), len, d);
    @(posedge clk);
    #1 check(route_chg == 1'b0, {tag, " R9 pulse ends"}, 32'(route_chg), 32'd0);
  endtask

  task automatic bus_read(input logic [15:0] a, input int len, input string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = 2'(len);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = exp_read(int'(a), len);
    check(rsp_valid == 1'b1, "R10 rsp valid", 32'(rsp_valid), 32'd1);
    check(rsp_rdata == e, tag, rsp_rdata, e);
    check(route_chg == 1'b0, "R9 no pulse on read", 32'(route_chg), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) m_reg[i] = 16'h3210;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == 1'b0, "R1 no rsp", 32'(rsp_valid), 32'd0);
    check(route_chg == 1'b0, "R1 no pulse", 32'(route_chg), 32'd0);

    // R1 defaults through the bus, slot 30 bytes zero
    for (int a = 0; a < 16; a += 4) bus_read(16'(a), 3, "R1 reset read");
    sweep_routes();

    // R2: field bit 3 ignored; same-cycle lookup vs write (R9)
    @(negedge clk);
    lk_slot = 5'd27; lk_pin = 2'd0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'd4; req_len = 2'd0;
    req_wdata = 32'h0000_000D;
    #1 check(lk_pirq == 3'd0, "R9 old value in accept cycle", 32'(lk_pirq), 32'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_write(4, 0, 32'h0000_000D);
    check(route_chg == 1'b1, "R9 pulse", 32'(route_chg), 32'd1);
    check(lk_pirq == 3'd5, "R2 bit3 ignored new value", 32'(lk_pirq), 32'd5);

    // R3: write to slot 30 ignored
    bus_write(16'd10, 1, 32'h0000_7654, "R3");
    bus_read(16'd10, 1, "R3 fixed reads zero");
    for (int p = 0; p < 4; p++) check_route(FIXED, p, "R3 after write");

    // R5: 4-byte little-endian write across two registers
    bus_write(16'd0, 3, 32'h4567_0123, "R5");
    bus_read(16'd0, 0, "R5 byte0");
    bus_read(16'd3, 0, "R5 byte3");
    check_route(25, 1, "R5 route slot25");
    check_route(26, 3, "R5 route slot26");

    // R6: aliasing of high address bits
    bus_write(16'h4C0C, 1, 32'h0000_1536, "R6");
    bus_read(16'h000C, 1, "R6 alias read");
    check_route(31, 2, "R6 route slot31");

    // R7: clipping at the window end, no wrap onto offset 0
    bus_write(16'h003E, 3, 32'h7777_7777, "R7");
    bus_read(16'h0000, 1, "R7 offset0 untouched");
    bus_read(16'h003F, 3, "R7 read clipped");

    // R8: unimplemented bytes
    bus_write(16'h0020, 3, 32'hFFFF_FFFF, "R8");
    bus_write(16'h000E, 3, 32'h7777_7777, "R8");
    bus_read(16'h000E, 3, "R8 reads zero");
    sweep_routes();

    // R10: stall with a queued write, released on one edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'd2; req_len = 2'd1;
    rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    held = rsp_rdata;
    check(rsp_rdata == exp_read(2, 1), "R10 stalled data", rsp_rdata, exp_read(2, 1));
    req_write = 1'b1; req_addr = 16'd2; req_len = 2'd0; req_wdata = 32'h0000_0044;
    for (int c = 0; c < 3; c++) begin
      #1 check(req_ready == 1'b0, "R10 blocked", 32'(req_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_rdata == held, "R10 held", rsp_rdata, held);
      check(route_chg == 1'b0, "R10 write not taken", 32'(route_chg), 32'd0);
    end
    rsp_ready = 1'b1;
    #1 check(req_ready == 1'b1, "R10 ready on drain", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_write(2, 0, 32'h0000_0044);
    check(rsp_valid == 1'b0, "R10 drained", 32'(rsp_valid), 32'd0);
    check(route_chg == 1'b1, "R9 pulse after drain", 32'(route_chg), 32'd1);
    check_route(26, 0, "R10 queued write landed");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int len;
      a = 16'($urandom);
      if ($urandom % 2 == 0) a = 16'($urandom % 16);
      len = int'($urandom % 4);
      if ($urandom % 2 == 0) bus_write(a, len, $urandom, "R5 random");
      else                   bus_read(a, len, "R5 random read");
      check_route(int'($urandom % 32), int'($urandom % 4), "R2 random route");
    end
    sweep_routes();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule